// File: doc/BRIEF.md
# Control-Read Transfer Sequencer

This block runs a complete control-read transfer on the default control endpoint without software. It sits next to the endpoint register and FIFO block. It receives the endpoint events, pops the eight request bytes from the receive FIFO and fills the transmit FIFO from a descriptor memory port. It drives the register bit controls that the service routine would otherwise write: arm the IN packet, mark the data end, acknowledge the received OUT packet, drop the IN arm and flush the transmit FIFO.

The transfer moves through three stages. In the setup stage the block waits for an OUT event, drains the request bytes and takes the request length from bytes 6 (low) and 7 (high). The length it sends is the smaller of the request length and the descriptor length. In the data stage it sends packets of at most eight bytes. It moves to the next packet only after an IN-done event, and it marks the data end on the last packet. That is the first short packet, or the packet that uses up the data. In the status stage it waits for the zero-length OUT. An OUT that comes while the block is waiting to send more data is taken as an early status stage, and the block aborts back to the setup stage.

Top module: `ctrd_seq`

## Requirements
- R1: After reset, stage reads 0 (setup) and rx_pop, tx_wr, set_ipr, set_de, clr_opr, clr_ipr and tx_flush are all low.
- R2: In the setup stage the block pops nothing until an OUT event. After the event it pops exactly 8 bytes, and never while rx_count is 0.
- R3: The bytes written to the transmit FIFO number min(request length, desc_len), where the request length is byte 7 * 256 + byte 6. They are the descriptor bytes in address order, starting from address 0 on every transfer.
- R4: Each packet holds min(remaining, 8) bytes. set_ipr pulses only when tx_count equals that packet size.
- R5: clr_opr pulses together with set_ipr on the first packet of a transfer and on no later packet.
- R6: set_de pulses together with set_ipr on the last packet, and only on it. The last packet is the first packet shorter than 8, or the packet that empties the data. A length of 0 gives one empty packet, and an exact multiple of 8 ends on a full packet with no empty packet after it. The stage then reads 2 (status).
- R7: After a packet that is not the last, the stage reads 1 (data). No byte is written until an IN-done event arrives.
- R8: In the status stage an OUT event gives one clr_opr pulse, and the stage returns to 0.
- R9: An OUT event while the block is waiting to send the next packet gives tx_flush, clr_ipr and clr_opr in the same cycle. The stage returns to 0, and no further byte or set_ipr follows.
- R10: An IN-done event in the setup or status stage has no effect: no write, no pop and no change of stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_out_evt | input | 1 | Pulse: OUT or SETUP packet received (OUT-ready bit set) |
| ep_in_evt | input | 1 | Pulse: armed IN packet acknowledged by host (IN-ready bit cleared) |
| desc_len | input | 16 | Number of descriptor bytes available |
| rx_count | input | 4 | Bytes waiting in receive FIFO |
| rx_data | input | 8 | Receive FIFO head byte |
| rx_pop | output | 1 | Pop one byte from receive FIFO |
| tx_count | input | 4 | Bytes held in transmit FIFO |
| tx_wr | output | 1 | Write tx_data into transmit FIFO |
| tx_data | output | 8 | Byte to write |
| mem_addr | output | 16 | Descriptor memory address |
| mem_data | input | 8 | Descriptor byte at mem_addr (same cycle) |
| set_ipr | output | 1 | Arm the IN packet |
| set_de | output | 1 | Mark data end |
| clr_opr | output | 1 | Acknowledge the received OUT packet |
| clr_ipr | output | 1 | Withdraw the IN arm |
| tx_flush | output | 1 | Empty the transmit FIFO |
| stage | output | 2 | Current stage: 0 setup, 1 data, 2 status |

## Verification
A wrong internal state shows up at the ports within the packet in which it happens. A bad remaining count makes the next set_ipr carry the wrong size or set_de fall on the wrong packet, and the bench compares both at every packet. A stage machine that leaves its wait states too early writes bytes before the IN-done event, or misses the early-status abort. Either one shows as extra tx_wr pulses or a stage code other than 0 within a few cycles of the event. A stale address or length from the previous transfer shows as wrong data on the first byte of the next transfer.

// File: rtl/ctrd_pkg.sv
package ctrd_pkg;
    localparam int LEN_W       = 16;
    localparam int CNT_W       = 4;
    localparam int PKT_BYTES   = 8;
    localparam int SETUP_BYTES = 8;
    localparam int LEN_LO_IDX  = 6;
    localparam int LEN_HI_IDX  = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GRAB,
        ST_FILL,
        ST_CHECK,
        ST_ARM,
        ST_HOLD,
        ST_STATUS
    } seq_state_e;

    typedef enum logic [1:0] {
        STG_SETUP  = 2'd0,
        STG_DATA   = 2'd1,
        STG_STATUS = 2'd2
    } stage_e;

    typedef struct packed {
        logic set_ipr;
        logic set_de;
        logic clr_opr;
        logic clr_ipr;
        logic flush;
    } reg_ctl_t;

    function automatic logic [LEN_W-1:0] len_min(input logic [LEN_W-1:0] a,
                                                 input logic [LEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic stage_e stage_of(input seq_state_e s);
        case (s)
            ST_IDLE, ST_GRAB:              return STG_SETUP;
            ST_STATUS:                     return STG_STATUS;
            default:                       return STG_DATA;
        endcase
    endfunction
endpackage

// File: rtl/ctrd_setup_rx.sv
module ctrd_setup_rx
    import ctrd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [7:0]       rx_data,
    output logic             rx_pop,
    output logic             done,
    output logic [LEN_W-1:0] req_len
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SETUP_BYTES);

    logic [CNT_W-1:0] idx;
    logic [7:0]       len_lo;
    logic [7:0]       len_hi;

    assign rx_pop  = en && (idx < LAST_IDX) && (rx_count != '0);
    assign done    = en && (idx == LAST_IDX) && (rx_count == '0);
    assign req_len = LEN_W'({len_hi, len_lo});

    always_ff @(posedge clk) begin
        if (rst) begin
            idx    <= '0;
            len_lo <= '0;
            len_hi <= '0;
        end else if (start) begin
            idx <= '0;
        end else if (rx_pop) begin
            idx <= idx + 1'b1;
            if (idx == CNT_W'(LEN_LO_IDX)) len_lo <= rx_data;
            if (idx == CNT_W'(LEN_HI_IDX)) len_hi <= rx_data;
        end
    end

    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> (rx_count != '0)); // R2
endmodule

// File: rtl/ctrd_pkt_plan.sv
module ctrd_pkt_plan
    import ctrd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic [LEN_W-1:0] total,
    input  logic             fill_en,
    input  logic             advance,
    output logic [LEN_W-1:0] mem_addr,
    output logic             tx_wr,
    output logic             fill_done,
    output logic [CNT_W-1:0] pkt_len,
    output logic             last
);
    localparam logic [LEN_W-1:0] FULL_L = LEN_W'(PKT_BYTES);
    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(PKT_BYTES);

    logic [LEN_W-1:0] remain;
    logic [LEN_W-1:0] addr;
    logic [CNT_W-1:0] cnt;

    assign pkt_len   = (remain >= FULL_L) ? FULL_C : CNT_W'(remain);
    assign last      = (pkt_len != FULL_C) || (remain == FULL_L);
    assign tx_wr     = fill_en && (cnt < pkt_len);
    assign fill_done = (cnt == pkt_len);
    assign mem_addr  = addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
            addr   <= '0;
            cnt    <= '0;
        end else if (init) begin
            remain <= total;
            addr   <= '0;
            cnt    <= '0;
        end else if (advance) begin
            remain <= remain - LEN_W'(pkt_len);
            cnt    <= '0;
        end else if (tx_wr) begin
            addr <= addr + 1'b1;
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ctrd_seq.sv
module ctrd_seq
    import ctrd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ep_out_evt,
    input  logic             ep_in_evt,
    input  logic [LEN_W-1:0] desc_len,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [7:0]       rx_data,
    output logic             rx_pop,
    input  logic [CNT_W-1:0] tx_count,
    output logic             tx_wr,
    output logic [7:0]       tx_data,
    output logic [LEN_W-1:0] mem_addr,
    input  logic [7:0]       mem_data,
    output logic             set_ipr,
    output logic             set_de,
    output logic             clr_opr,
    output logic             clr_ipr,
    output logic             tx_flush,
    output logic [1:0]       stage
);
    seq_state_e       state, nxt;
    logic             first;
    logic             out_pend, in_pend;
    logic             take_out, drop_in;
    logic             cap_start, cap_done;
    logic             plan_init, plan_adv;
    logic             fill_done, last;
    logic [CNT_W-1:0] pkt_len;
    logic [LEN_W-1:0] req_len;
    reg_ctl_t         ctl;

    ctrd_setup_rx u_setup (
        .clk      (clk),
        .rst      (rst),
        .start    (cap_start),
        .en       (state == ST_GRAB),
        .rx_count (rx_count),
        .rx_data  (rx_data),
        .rx_pop   (rx_pop),
        .done     (cap_done),
        .req_len  (req_len)
    );

    ctrd_pkt_plan u_plan (
        .clk       (clk),
        .rst       (rst),
        .init      (plan_init),
        .total     (len_min(req_len, desc_len)),
        .fill_en   (state == ST_FILL),
        .advance   (plan_adv),
        .mem_addr  (mem_addr),
        .tx_wr     (tx_wr),
        .fill_done (fill_done),
        .pkt_len   (pkt_len),
        .last      (last)
    );

    assign tx_data  = mem_data;
    assign set_ipr  = ctl.set_ipr;
    assign set_de   = ctl.set_de;
    assign clr_opr  = ctl.clr_opr;
    assign clr_ipr  = ctl.clr_ipr;
    assign tx_flush = ctl.flush;
    assign stage    = stage_of(state);

    always_comb begin
        nxt       = state;
        ctl       = '0;
        take_out  = 1'b0;
        drop_in   = 1'b0;
        cap_start = 1'b0;
        plan_init = 1'b0;
        plan_adv  = 1'b0;
        case (state)
            ST_IDLE: begin
                drop_in = 1'b1;
                if (out_pend) begin
                    take_out  = 1'b1;
                    cap_start = 1'b1;
                    nxt       = ST_GRAB;
                end
            end
            ST_GRAB: begin
                if (cap_done) begin
                    plan_init = 1'b1;
                    nxt       = ST_FILL;
                end
            end
            ST_FILL:  if (fill_done) nxt = ST_CHECK;
            ST_CHECK: if (tx_count == pkt_len) nxt = ST_ARM;
            ST_ARM: begin
                ctl.set_ipr = 1'b1;
                ctl.clr_opr = first;
                ctl.set_de  = last;
                plan_adv    = 1'b1;
                nxt         = last ? ST_STATUS : ST_HOLD;
            end
            ST_HOLD: begin
                if (out_pend) begin
                    take_out    = 1'b1;
                    drop_in     = 1'b1;
                    ctl.flush   = 1'b1;
                    ctl.clr_ipr = 1'b1;
                    ctl.clr_opr = 1'b1;
                    nxt         = ST_IDLE;
                end else if (in_pend) begin
                    drop_in = 1'b1;
                    nxt     = ST_FILL;
                end
            end
            ST_STATUS: begin
                drop_in = 1'b1;
                if (out_pend) begin
                    take_out    = 1'b1;
                    ctl.clr_opr = 1'b1;
                    nxt         = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            first    <= 1'b0;
            out_pend <= 1'b0;
            in_pend  <= 1'b0;
        end else begin
            state    <= nxt;
            out_pend <= ep_out_evt | (out_pend & ~take_out);
            in_pend  <= ep_in_evt  | (in_pend  & ~drop_in);
            if (plan_init)     first <= 1'b1;
            else if (plan_adv) first <= 1'b0;
        end
    end

    AST_ARM_SIZE_MATCH: assert property (@(posedge clk) disable iff (rst)
        set_ipr |-> (tx_count == pkt_len)); // R4
    AST_DE_WITH_ARM: assert property (@(posedge clk) disable iff (rst)
        set_de |-> set_ipr); // R6
    AST_ABORT_TRIO: assert property (@(posedge clk) disable iff (rst)
        tx_flush |-> (clr_ipr && clr_opr && !set_ipr)); // R9
    AST_WRITE_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        tx_wr |-> (stage == STG_DATA)); // R7
    AST_STATUS_HOME: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STATUS && out_pend) |=> (stage == STG_SETUP)); // R8
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({set_ipr, tx_flush, rx_pop})); // R9
endmodule

// File: tb/sim_ctrd_seq.sv
module sim_ctrd_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ep_out_evt = 1'b0, ep_in_evt = 1'b0;
    logic [15:0] desc_len = '0;
    logic [3:0]  rx_count, tx_count;
    logic [7:0]  rx_data, tx_data, mem_data;
    logic [15:0] mem_addr;
    logic        rx_pop, tx_wr, set_ipr, set_de, clr_opr, clr_ipr, tx_flush;
    logic [1:0]  stage;
    logic        host_load = 1'b0, host_take = 1'b0;
    logic [7:0]  su [8];
    logic [2:0]  rx_ptr;

    int checks = 0, fails = 0;
    int n_pop = 0, n_wr = 0, n_arm = 0, n_clr_opr = 0, n_flush = 0, trio_bad = 0;
    int data_bad = 0, xfer_base = 0;
    int arm_size [256];
    bit arm_de [256];
    bit arm_opr [256];

    always #2.5 clk = ~clk;

    function automatic logic [7:0] fdat(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    assign mem_data = fdat(int'(mem_addr));
    assign rx_data  = su[rx_ptr];

    ctrd_seq u0 (
        .clk(clk), .rst(rst), .ep_out_evt(ep_out_evt), .ep_in_evt(ep_in_evt),
        .desc_len(desc_len), .rx_count(rx_count), .rx_data(rx_data), .rx_pop(rx_pop),
        .tx_count(tx_count), .tx_wr(tx_wr), .tx_data(tx_data), .mem_addr(mem_addr),
        .mem_data(mem_data), .set_ipr(set_ipr), .set_de(set_de), .clr_opr(clr_opr),
        .clr_ipr(clr_ipr), .tx_flush(tx_flush), .stage(stage)
    );

    always @(posedge clk) begin
        if (rst) begin
            rx_count <= '0; rx_ptr <= '0; tx_count <= '0;
        end else begin
            if (host_load) begin rx_count <= 4'd8; rx_ptr <= '0; end
            else if (rx_pop) begin rx_count <= rx_count - 1'b1; rx_ptr <= rx_ptr + 1'b1; end
            if (tx_flush || host_take) tx_count <= '0;
            else if (tx_wr) tx_count <= tx_count + 1'b1;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_pop) n_pop++;
            if (tx_wr) begin
                if (tx_data !== fdat(n_wr - xfer_base)) data_bad++;
                n_wr++;
            end
            if (set_ipr) begin
                arm_size[n_arm % 256] = int'(tx_count);
                arm_de[n_arm % 256]   = set_de;
                arm_opr[n_arm % 256]  = clr_opr;
                n_arm++;
            end
            if (clr_opr) n_clr_opr++;
            if (tx_flush) begin
                n_flush++;
                if (!(clr_ipr && clr_opr)) trio_bad++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_arm(input int target);
        for (int i = 0; i < 400; i++) begin
            if (n_arm >= target) return;
            @(posedge clk);
        end
        chk(1'b0, "R4 arm timeout", n_arm, target);
    endtask

    task automatic xfer(input int wl, input int dl, input int ab);
        int total, npk, arm_base, wr_base, pop_base, bad_base, w, o, fl;
        total = (wl < dl) ? wl : dl;
        npk   = (total == 0) ? 1 : (total + 7) / 8;
        tick(1);
        desc_len = 16'(dl);
        su[0] = 8'h80; su[1] = 8'h06; su[2] = 8'h00; su[3] = 8'h01;
        su[4] = 8'h00; su[5] = 8'h00; su[6] = 8'(wl & 255); su[7] = 8'((wl >> 8) & 255);
        arm_base = n_arm; wr_base = n_wr; pop_base = n_pop; bad_base = data_bad;
        xfer_base = n_wr;
        host_load = 1'b1; ep_out_evt = 1'b1;
        tick(1);
        host_load = 1'b0; ep_out_evt = 1'b0;
        for (int k = 0; k < npk; k++) begin
            int esz, idx;
            esz = ((total - 8 * k) < 8) ? (total - 8 * k) : 8;
            wait_arm(arm_base + k + 1);
            @(negedge clk);
            idx = (arm_base + k) % 256;
            chk(arm_size[idx] == esz, "R4 packet size", arm_size[idx], esz);
            chk(arm_de[idx] == (k == npk - 1), "R6 data end flag", int'(arm_de[idx]), int'(k == npk - 1));
            chk(arm_opr[idx] == (k == 0), "R5 opr clear on first", int'(arm_opr[idx]), int'(k == 0));
            if (k == 0) chk(n_pop - pop_base == 8, "R2 setup pops", n_pop - pop_base, 8);
            if (k == npk - 1) begin
                chk(n_wr - wr_base == total, "R3 byte total", n_wr - wr_base, total);
                chk(data_bad == bad_base, "R3 byte values", data_bad - bad_base, 0);
                tick(2); @(negedge clk);
                chk(stage == 2'd2, "R6 status stage", int'(stage), 2);
                w = n_wr;
                host_take = 1'b1; ep_in_evt = 1'b1;
                tick(1);
                host_take = 1'b0; ep_in_evt = 1'b0;
                tick(6); @(negedge clk);
                chk(stage == 2'd2 && n_wr == w && n_arm == arm_base + npk,
                    "R10 in event in status", n_wr - w, 0);
                o = n_clr_opr;
                ep_out_evt = 1'b1;
                tick(1);
                ep_out_evt = 1'b0;
                tick(4); @(negedge clk);
                chk(n_clr_opr - o == 1, "R8 status opr clear", n_clr_opr - o, 1);
                chk(stage == 2'd0, "R8 back to setup", int'(stage), 0);
                return;
            end
            if (k == ab) begin
                fl = n_flush;
                ep_out_evt = 1'b1;
                tick(1);
                ep_out_evt = 1'b0;
                tick(4); @(negedge clk);
                chk(n_flush - fl == 1 && trio_bad == 0, "R9 abort controls", n_flush - fl, 1);
                chk(stage == 2'd0, "R9 abort stage", int'(stage), 0);
                w = n_wr;
                tick(10); @(negedge clk);
                chk(n_wr == w && n_arm == arm_base + k + 1, "R9 nothing after abort", n_wr - w, 0);
                return;
            end
            chk(stage == 2'd1, "R7 data stage", int'(stage), 1);
            w = n_wr;
            tick(5); @(negedge clk);
            chk(n_wr == w, "R7 no load before ack", n_wr - w, 0);
            host_take = 1'b1; ep_in_evt = 1'b1;
            tick(1);
            host_take = 1'b0; ep_in_evt = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int dls [10] = '{0, 1, 7, 8, 9, 15, 16, 17, 24, 33};
        int wls [6]  = '{0, 3, 8, 16, 20, 300};
        for (int i = 0; i < 8; i++) su[i] = '0;
        tick(4);
        rst = 1'b0;
        @(negedge clk);
        chk(stage == 2'd0 && !rx_pop && !tx_wr && !set_ipr && !set_de && !clr_opr
            && !clr_ipr && !tx_flush, "R1 reset state", int'(stage), 0);
        ep_in_evt = 1'b1;
        tick(1);
        ep_in_evt = 1'b0;
        tick(6); @(negedge clk);
        chk(stage == 2'd0 && n_wr == 0, "R10 in event in setup", n_wr, 0);
        chk(n_pop == 0, "R2 no pop before setup", n_pop, 0);
        for (int a = 0; a < 10; a++)
            for (int b = 0; b < 6; b++)
                xfer(wls[b], dls[a], -1);
        xfer(64, 24, 0);
        xfer(18, 40, 1);
        xfer(255, 9, 0);
        xfer(40, 40, 3);
        xfer(12, 100, -1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule